// File: doc/BRIEF.md
# Oversampled Serial Receiver with Mute and Wake-Up

This block receives asynchronous serial characters: one low start bit, `DATA_W` data bits sent least significant bit first, and one high stop bit. A tick input `tick16` marks the oversampling instants, with `OSR` ticks per bit. Each accepted character is placed in a receive register and flagged. A second character that arrives before the first is read raises an overrun. A line that stays high for a full frame time after a character raises an idle flag. One interrupt line combines the data and idle conditions, each behind its own enable.

Software can put the receiver in mute mode. While muted, characters are still shifted in, but they set no flags and do not reach the receive register. The receiver leaves mute by hardware when it sees the wake-up condition chosen by `wake_addr`:

- With `wake_addr` low, the condition is an idle line.
- With `wake_addr` high, the condition is a character whose most significant bit is set. That character is itself delivered.

Software changes the mute state with a write strobe. The block accepts or ignores that write according to the wake mode and the state of the receive register.

Top module: `uart_mute_rx`

## Requirements
- R1: After reset, `rx_data` is 0 and `rx_full`, `overrun`, `idle_flag`, `mute_on` and `irq` are all 0.
- R2: A frame (start 0, `DATA_W` data bits LSB first, stop 1) is captured when the stop bit is sampled high at mid-bit. If not muted, the data appears on `rx_data` and `rx_full` is set. `rd_ack` clears `rx_full`.
- R3: A start is detected only on a high-to-low transition of the line. It is confirmed when at least two of the samples at ticks OSR/2-1, OSR/2 and OSR/2+1 are low. Otherwise the receiver returns to searching for a start bit, and a short glitch delivers nothing.
- R4: A frame whose stop bit is sampled low is dropped and changes no flag.
- R5: A character that completes while `rx_full` is 1 sets `overrun` and is discarded, so `rx_data` keeps the older value. `rd_ack` clears both `rx_full` and `overrun`.
- R6: After a captured frame, `(DATA_W+2)*OSR` consecutive high ticks set `idle_flag`. This happens at most once per captured frame. It does not happen if no frame has been captured since the receiver was enabled. `idle_ack` clears the flag.
- R7: `irq` is 1 when `data_irq_en` is set and `rx_full` or `overrun` is 1, or when `idle_irq_en` is set and `idle_flag` is 1.
- R8: While `rx_en` is 0 the line is ignored and no flag is set. After `rx_en` is raised, the receiver searches for a start bit.
- R9: A `mute_wr` pulse loads `mute_wdata` into `mute_on` (1 = muted, 0 = active). With `wake_addr` at 0 the write is accepted even while `rx_full` is 1.
- R10: While muted, received characters do not change `rx_data`, `rx_full`, `overrun` or `idle_flag`, except the waking character of R12.
- R11: With `wake_addr` at 0, an idle line clears `mute_on` without setting `idle_flag`. This works only if a frame has been captured since enable or since the last idle detection.
- R12: With `wake_addr` at 1, a muted character with its MSB set clears `mute_on` and is delivered with `rx_full` set. A character with MSB 0 is discarded, and an idle line does not wake the receiver.
- R13: With `wake_addr` at 1, `mute_wr` is ignored while `rx_full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| tick16 | input | 1 | Oversampling tick, OSR per bit |
| rx_in | input | 1 | Serial line, idle high |
| wake_addr | input | 1 | Wake method: 0 idle line, 1 MSB-marked character |
| mute_wr | input | 1 | Software write strobe for the mute state |
| mute_wdata | input | 1 | Mute value written by `mute_wr` |
| rd_ack | input | 1 | Receive register read; clears `rx_full` and `overrun` |
| idle_ack | input | 1 | Clears `idle_flag` |
| data_irq_en | input | 1 | Enables interrupt on `rx_full` or `overrun` |
| idle_irq_en | input | 1 | Enables interrupt on `idle_flag` |
| rx_data | output | DATA_W | Receive register |
| rx_full | output | 1 | Receive register holds unread data |
| overrun | output | 1 | A character was lost |
| idle_flag | output | 1 | Idle line seen after a character |
| mute_on | output | 1 | Receiver muted |
| irq | output | 1 | Combined interrupt request |

## Verification
The receive path is driven with several patterns:

- Distinct byte values check bit order and the scoreboard match.
- Back-to-back frames without a read separate overrun from normal delivery.
- A three-tick low glitch separates a confirmed start from a rejected one.
- A frame with a low stop bit shows that framing errors are dropped.

Mute is tried in both wake modes, with these pairs of cases:

- A muted plain character against a muted MSB-marked one.
- An idle line after a captured character against one with no character since enable.
- Mute writes with the receive register full against the same writes with it empty, so that the lock of R13 is told apart from the free writes of R9.

// File: rtl/uart_mute_rx_pkg.sv
package uart_mute_rx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } fr_state_e;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_mute_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rx,
    output logic              char_done,
    output logic [DATA_W-1:0] char_data,
    output logic              idle_det
);

    localparam int CNT_W      = $clog2(OSR);
    localparam int BIT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int IDLE_TICKS = (DATA_W + 2) * OSR;
    localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
    localparam logic [CNT_W-1:0]  MID      = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0]  VOTE_A   = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0]  VOTE_C   = CNT_W'(OSR / 2 + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(DATA_W - 1);
    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_TICKS - 1);

    typedef struct packed {
        fr_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  nbit;
        logic [DATA_W-1:0] shreg;
        logic [1:0]        votes;
        logic              last_rx;
        logic              armed;
        logic [IDLE_W-1:0] idle_cnt;
    } fr_reg_t;

    localparam fr_reg_t FR_RESET = '{
        st:       FR_IDLE,
        cnt:      '0,
        nbit:     '0,
        shreg:    '0,
        votes:    '0,
        last_rx:  1'b0,
        armed:    1'b0,
        idle_cnt: '0
    };

    fr_reg_t q, d;
    logic [1:0] low_total;

    always_comb begin
        d         = q;
        char_done = 1'b0;
        idle_det  = 1'b0;
        low_total = q.votes + {1'b0, ~rx};
        if (!en) begin
            d = FR_RESET;
        end else if (tick) begin
            unique case (q.st)
                FR_IDLE: begin
                    d.last_rx = rx;
                    if (!rx && q.last_rx) begin
                        d.st       = FR_START;
                        d.cnt      = '0;
                        d.votes    = '0;
                        d.idle_cnt = '0;
                    end else if (!rx) begin
                        d.idle_cnt = '0;
                    end else if (q.armed) begin
                        if (q.idle_cnt == IDLE_LAST) begin
                            idle_det   = 1'b1;
                            d.armed    = 1'b0;
                            d.idle_cnt = '0;
                        end else begin
                            d.idle_cnt = q.idle_cnt + 1'b1;
                        end
                    end
                end
                FR_START: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == VOTE_A || q.cnt == MID) begin
                        d.votes = low_total;
                    end
                    if (q.cnt == VOTE_C && low_total < 2'd2) begin
                        d.st      = FR_IDLE;
                        d.cnt     = '0;
                        d.last_rx = rx;
                    end else if (q.cnt == CNT_LAST) begin
                        d.st   = FR_DATA;
                        d.cnt  = '0;
                        d.nbit = '0;
                    end
                end
                FR_DATA: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID) begin
                        d.shreg = {rx, q.shreg[DATA_W-1:1]};
                    end
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        if (q.nbit == BIT_LAST) d.st = FR_STOP;
                        else                    d.nbit = q.nbit + 1'b1;
                    end
                end
                FR_STOP: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == MID) begin
                        d.st       = FR_IDLE;
                        d.cnt      = '0;
                        d.last_rx  = rx;
                        d.idle_cnt = '0;
                        if (rx) begin
                            char_done = 1'b1;
                            d.armed   = 1'b1;
                        end
                    end
                end
                default: d = FR_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FR_RESET;
        else        q <= d;
    end

    assign char_data = q.shreg;

endmodule

// File: rtl/rx_status.sv
module rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              idle_det,
    input  logic              wake_addr,
    input  logic              mute_wr,
    input  logic              mute_wdata,
    input  logic              rd_ack,
    input  logic              idle_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              idle_flag,
    output logic              mute_on
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              idle;
        logic              mute;
    } st_reg_t;

    st_reg_t q, d;
    logic    deliver;

    always_comb begin
        d       = q;
        deliver = 1'b0;
        if (rd_ack) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end
        if (idle_ack) d.idle = 1'b0;
        // Software write; locked in address-mark mode while data is unread
        if (mute_wr && !(wake_addr && q.full)) d.mute = mute_wdata;
        // Character delivery and address-mark wake-up
        if (char_done) begin
            if (!q.mute) begin
                deliver = 1'b1;
            end else if (wake_addr && char_data[DATA_W-1]) begin
                deliver = 1'b1;
                d.mute  = 1'b0;
            end
        end
        // Idle line: flag when active, wake when muted in idle mode
        if (idle_det) begin
            if (q.mute) begin
                if (!wake_addr) d.mute = 1'b0;
            end else begin
                d.idle = 1'b1;
            end
        end
        if (deliver) begin
            if (q.full && !rd_ack) begin
                d.ovr = 1'b1;
            end else begin
                d.full = 1'b1;
                d.data = char_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data   = q.data;
    assign rx_full   = q.full;
    assign overrun   = q.ovr;
    assign idle_flag = q.idle;
    assign mute_on   = q.mute;

endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick16,
    input  logic              rx_in,
    input  logic              wake_addr,
    input  logic              mute_wr,
    input  logic              mute_wdata,
    input  logic              rd_ack,
    input  logic              idle_ack,
    input  logic              data_irq_en,
    input  logic              idle_irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              idle_flag,
    output logic              mute_on,
    output logic              irq
);

    logic              rx_s;
    logic              char_done;
    logic [DATA_W-1:0] char_data;
    logic              idle_det;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (rx_s)
    );

    rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .tick      (tick16),
        .rx        (rx_s),
        .char_done (char_done),
        .char_data (char_data),
        .idle_det  (idle_det)
    );

    rx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_done  (char_done),
        .char_data  (char_data),
        .idle_det   (idle_det),
        .wake_addr  (wake_addr),
        .mute_wr    (mute_wr),
        .mute_wdata (mute_wdata),
        .rd_ack     (rd_ack),
        .idle_ack   (idle_ack),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .overrun    (overrun),
        .idle_flag  (idle_flag),
        .mute_on    (mute_on)
    );

    assign irq = (data_irq_en && (rx_full || overrun)) || (idle_irq_en && idle_flag);

endmodule

// File: rtl/uart_mute_rx_chk.sv
module uart_mute_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic wake_addr,
    input logic mute_wr,
    input logic rd_ack,
    input logic rx_full,
    input logic overrun,
    input logic mute_on
);

    // R5: overrun only ever accompanies unread data
    p_ovr_with_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rx_full);

    // R5: overrun can only appear while data was already waiting
    p_ovr_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));

    // R5: a read always leaves overrun clear
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !overrun);

    // R8: a disabled receiver delivers nothing
    p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !$rose(rx_full));

    // R10: while muted the register only fills together with leaving mute
    p_muted_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_on && !rx_full) |=> (!rx_full || !mute_on));

    // R13: locked mute write cannot enter mute
    p_mute_lock_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_addr && rx_full && !mute_on && mute_wr) |=> !mute_on);

endmodule

bind uart_mute_rx uart_mute_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .wake_addr (wake_addr),
    .mute_wr   (mute_wr),
    .rd_ack    (rd_ack),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .mute_on   (mute_on)
);

// File: tb/uart_mute_rx_bench.sv
module uart_mute_rx_bench;

    localparam int BIT_CLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_in = 1'b1;
    logic       wake_addr = 1'b0;
    logic       mute_wr = 1'b0;
    logic       mute_wdata = 1'b0;
    logic       rd_ack = 1'b0;
    logic       idle_ack = 1'b0;
    logic       data_irq_en = 1'b0;
    logic       idle_irq_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun, idle_flag, mute_on, irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    uart_mute_rx u_uart_mute_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .rx_in(rx_in),
        .wake_addr(wake_addr), .mute_wr(mute_wr), .mute_wdata(mute_wdata),
        .rd_ack(rd_ack), .idle_ack(idle_ack), .data_irq_en(data_irq_en),
        .idle_irq_en(idle_irq_en), .rx_data(rx_data), .rx_full(rx_full),
        .overrun(overrun), .idle_flag(idle_flag), .mute_on(mute_on), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: every new delivery is compared against the scoreboard queue
    initial begin
        logic prev_full = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rx_full && !prev_full) begin
                if (exp_q.size() == 0) begin
                    chk("R2/R10 unexpected delivery", int'(rx_data), -1);
                end else begin
                    chk("R2 delivered data", int'(rx_data), int'(exp_q.pop_front()));
                end
            end
            prev_full = rx_full;
        end
    end

    task automatic send_frame(input logic [7:0] b, input logic stop_bit);
        rx_in = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rx_in = stop_bit;
        repeat (BIT_CLK) @(negedge clk);
        rx_in = 1'b1;
    endtask

    task automatic send_expect(input logic [7:0] b);
        exp_q.push_back(b);
        send_frame(b, 1'b1);
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT_CLK) @(negedge clk);
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_mute(input logic v);
        mute_wdata = v;
        mute_wr    = 1'b1;
        @(negedge clk);
        mute_wr    = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", int'(rx_data), 0);
        chk("R1 rx_full", int'(rx_full), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 idle_flag", int'(idle_flag), 0);
        chk("R1 mute_on", int'(mute_on), 0);
        chk("R1 irq", int'(irq), 0);

        // R8: disabled receiver ignores a frame
        send_frame(8'h99, 1'b1);
        wait_bits(1);
        chk("R8 disabled no data", int'(rx_full), 0);
        rx_en = 1'b1;
        wait_bits(1);

        // R6/R11: no frame since enable, idle wake must not happen
        write_mute(1'b1);
        chk("R9 mute written", int'(mute_on), 1);
        wait_bits(12);
        chk("R11 no wake without prior frame", int'(mute_on), 1);
        chk("R6 no idle without prior frame", int'(idle_flag), 0);
        write_mute(1'b0);
        chk("R9 mute cleared", int'(mute_on), 0);

        // R2/R7: normal reception and interrupt
        data_irq_en = 1'b1;
        send_expect(8'hA5);
        chk("R2 rx_full set", int'(rx_full), 1);
        chk("R7 irq on data", int'(irq), 1);
        data_irq_en = 1'b0;
        @(negedge clk);
        chk("R7 irq masked", int'(irq), 0);
        data_irq_en = 1'b1;
        // R9: idle-wake mode accepts writes while data is unread
        write_mute(1'b1);
        chk("R9 write with data unread", int'(mute_on), 1);
        write_mute(1'b0);
        pulse_ack();
        chk("R2 ack clears rx_full", int'(rx_full), 0);
        chk("R7 irq drops", int'(irq), 0);

        // R5: overrun keeps older data
        send_expect(8'h3C);
        send_frame(8'h5A, 1'b1);
        chk("R5 overrun set", int'(overrun), 1);
        chk("R5 older data kept", int'(rx_data), 'h3C);
        chk("R7 irq on overrun", int'(irq), 1);
        pulse_ack();
        chk("R5 ack clears overrun", int'(overrun), 0);
        chk("R5 ack clears rx_full", int'(rx_full), 0);

        // R6: idle timing and one flag per frame
        idle_irq_en = 1'b1;
        data_irq_en = 1'b0;
        wait_bits(4);
        chk("R6 idle not early", int'(idle_flag), 0);
        wait_bits(8);
        chk("R6 idle set", int'(idle_flag), 1);
        chk("R7 irq on idle", int'(irq), 1);
        idle_ack = 1'b1;
        @(negedge clk);
        idle_ack = 1'b0;
        @(negedge clk);
        chk("R6 idle_ack clears", int'(idle_flag), 0);
        wait_bits(12);
        chk("R6 idle only once", int'(idle_flag), 0);
        idle_irq_en = 1'b0;

        // R3: glitch rejected, then valid frame accepted
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        wait_bits(2);
        chk("R3 glitch rejected", int'(rx_full), 0);
        send_expect(8'hC3);
        chk("R3 frame after glitch", int'(rx_full), 1);
        pulse_ack();

        // R4: low stop bit drops the frame
        send_frame(8'h7E, 1'b0);
        wait_bits(1);
        chk("R4 framing error dropped", int'(rx_full), 0);

        // R11/R10: idle-line wake-up
        wake_addr = 1'b0;
        send_expect(8'h11);
        pulse_ack();
        write_mute(1'b1);
        send_frame(8'h22, 1'b1);
        chk("R10 muted char not flagged", int'(rx_full), 0);
        chk("R10 muted rx_data kept", int'(rx_data), 'h11);
        wait_bits(12);
        chk("R11 idle wakes", int'(mute_on), 0);
        chk("R11 no idle flag on wake", int'(idle_flag), 0);
        send_expect(8'h44);
        chk("R11 active after wake", int'(rx_full), 1);
        pulse_ack();
        wait_bits(12);
        idle_ack = 1'b1;
        @(negedge clk);
        idle_ack = 1'b0;

        // R12/R13: address-mark wake-up
        wake_addr = 1'b1;
        write_mute(1'b1);
        chk("R13 write accepted when empty", int'(mute_on), 1);
        send_frame(8'h22, 1'b1);
        chk("R12 plain char discarded", int'(rx_full), 0);
        wait_bits(12);
        chk("R12 idle does not wake", int'(mute_on), 1);
        send_expect(8'h85);
        chk("R12 mark wakes", int'(mute_on), 0);
        chk("R12 mark delivered", int'(rx_full), 1);
        chk("R12 mark data", int'(rx_data), 'h85);
        write_mute(1'b1);
        chk("R13 write ignored while full", int'(mute_on), 0);
        pulse_ack();
        write_mute(1'b1);
        chk("R13 write after read", int'(mute_on), 1);
        write_mute(1'b0);
        chk("R13 clear after read", int'(mute_on), 0);

        wait_bits(1);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule